// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block is a 16-bit bidirectional transceiver split into two independent 8-bit sections. Each section holds two banks of latches, one per direction. The A-to-B bank takes data from port A and presents it on port B. The B-to-A bank takes data from port B and presents it on port A. Each direction in each section has three active-low controls: a chip enable, a latch enable and a drive enable.

The chip enable gates both the latch and the output driver of its direction. With the chip enable low and the latch enable low, the latch is open: the opposite port shows the incoming data in the same cycle. It also stores that data at every clock edge. Once the latch enable goes high, the latch keeps the value it stored at the last edge where it was open. Later changes on the input no longer reach the output.

Each port appears as input data, output data and an active-high drive flag per section, so the design contains no tri-state cells. The surrounding pad logic turns the drive flag into a real tri-state buffer. The flow of data is level-controlled, with no back-pressure, so every pin is a plain control or data pin.

Top module: `dual_latch_xcvr`

## Requirements
- R1: While reset is low and after it is released, every stored latch value is zero and both drive flags are 0. A drive enabled on a closed latch then outputs zero.
- R2: While a direction's chip enable is 1, the latch of that direction keeps its stored value whatever its latch enable does, and its drive flag is 0.
- R3: With chip enable 0 and latch enable 0, the direction's output data equals the current input data of the source port in the same cycle, as long as the drive enable is also 0.
- R4: After the latch enable rises with chip enable 0, the output holds the source input sampled at the last rising clock edge where the latch was open. Later input changes have no effect.
- R5: A drive flag is 1 exactly when that direction's chip enable and drive enable are both 0. While the flag is 0, the matching output data bits are zero.
- R6: The B-to-A direction behaves like the A-to-B direction: it is controlled by the ba_* pins, takes b_in and drives a_out/a_oe.
- R7: Bit k of every control vector controls only section k. Section k covers data bits 8k to 8k+7 and drive flag bit k.
- R8: If both directions of one section are enabled to drive at once, both drive flags are 1 and each output carries its own latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; open latches store their input on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 16 | Data received on port A |
| b_in | input | 16 | Data received on port B |
| ab_en_n | input | 2 | A-to-B chip enable per section, active low |
| ab_le_n | input | 2 | A-to-B latch enable per section, active low (low = open) |
| ab_drv_n | input | 2 | A-to-B drive enable per section, active low |
| ba_en_n | input | 2 | B-to-A chip enable per section, active low |
| ba_le_n | input | 2 | B-to-A latch enable per section, active low (low = open) |
| ba_drv_n | input | 2 | B-to-A drive enable per section, active low |
| b_out | output | 16 | Data to drive onto port B |
| b_oe | output | 2 | Port B drive flag per section, active high |
| a_out | output | 16 | Data to drive onto port A |
| a_oe | output | 2 | Port A drive flag per section, active high |

## Verification
The assertions assume that the controls and input data are settled at each rising clock edge. They also assume that reset is released while the clock is running, so that "stored at the last open edge" has a single meaning. The stimulus changes all inputs only on the falling edge and compares outputs shortly afterwards, well before the next rising edge. The bench flags sections where both directions drive at once as contention events, but does not treat them as errors, because the block is required to drive both.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Active-low control triple for one direction of one section
  typedef struct packed {
    logic en_n;   // chip enable
    logic le_n;   // latch enable (low = open)
    logic drv_n;  // drive enable
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xcvr_pkg::dir_ctl_t ctl,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      dout,
  output logic              drive
);
  logic         open_w;
  logic [W-1:0] store_q;
  logic [W-1:0] lat_w;

  assign open_w = rst_n & ~ctl.en_n & ~ctl.le_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      store_q <= '0;
    else if (open_w) store_q <= din;
  end

  assign lat_w = open_w ? din : store_q;
  assign drive = rst_n & ~ctl.en_n & ~ctl.drv_n;
  assign dout  = drive ? lat_w : '0;

  // R2
  hold_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_w |=> $stable(store_q));
  // R4
  capture_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_w |=> store_q == $past(din));
  // R3
  flow_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en_n && !ctl.le_n && !ctl.drv_n) |-> dout == din);
  // R5
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> dout == '0);
  // R2
  ce_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.en_n |-> !drive);
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  xcvr_pkg::dir_ctl_t ab_ctl,
  input  xcvr_pkg::dir_ctl_t ba_ctl,
  input  logic [W-1:0]       a_in,
  input  logic [W-1:0]       b_in,
  output logic [W-1:0]       a_out,
  output logic               a_oe,
  output logic [W-1:0]       b_out,
  output logic               b_oe
);
  xcvr_latch_bank #(.W(W)) u_ab (
    .clk(clk), .rst_n(rst_n), .ctl(ab_ctl),
    .din(a_in), .dout(b_out), .drive(b_oe)
  );

  xcvr_latch_bank #(.W(W)) u_ba (
    .clk(clk), .rst_n(rst_n), .ctl(ba_ctl),
    .din(b_in), .dout(a_out), .drive(a_oe)
  );

  // R8
  both_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_ctl.en_n && !ab_ctl.drv_n && !ba_ctl.en_n && !ba_ctl.drv_n) |-> (a_oe && b_oe));
endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr #(
  parameter int DATA_W = 16,
  parameter int SEC_W  = 8,
  localparam int NSEC  = DATA_W / SEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [NSEC-1:0]   ab_en_n,
  input  logic [NSEC-1:0]   ab_le_n,
  input  logic [NSEC-1:0]   ab_drv_n,
  input  logic [NSEC-1:0]   ba_en_n,
  input  logic [NSEC-1:0]   ba_le_n,
  input  logic [NSEC-1:0]   ba_drv_n,
  output logic [DATA_W-1:0] b_out,
  output logic [NSEC-1:0]   b_oe,
  output logic [DATA_W-1:0] a_out,
  output logic [NSEC-1:0]   a_oe
);
  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    xcvr_pkg::dir_ctl_t ab_c, ba_c;
    assign ab_c = '{en_n: ab_en_n[s], le_n: ab_le_n[s], drv_n: ab_drv_n[s]};
    assign ba_c = '{en_n: ba_en_n[s], le_n: ba_le_n[s], drv_n: ba_drv_n[s]};

    xcvr_section #(.W(SEC_W)) u_sec (
      .clk   (clk),
      .rst_n (rst_n),
      .ab_ctl(ab_c),
      .ba_ctl(ba_c),
      .a_in  (a_in[s*SEC_W +: SEC_W]),
      .b_in  (b_in[s*SEC_W +: SEC_W]),
      .a_out (a_out[s*SEC_W +: SEC_W]),
      .a_oe  (a_oe[s]),
      .b_out (b_out[s*SEC_W +: SEC_W]),
      .b_oe  (b_oe[s])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (a_oe == '0 && b_oe == '0));
endmodule

// File: tb/sim_dual_latch_xcvr.sv
`timescale 1ns/1ps
module sim_dual_latch_xcvr;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] a_in = 0, b_in = 0;
  logic [1:0]  ab_en_n = 2'b11, ab_le_n = 2'b11, ab_drv_n = 2'b11;
  logic [1:0]  ba_en_n = 2'b11, ba_le_n = 2'b11, ba_drv_n = 2'b11;
  logic [15:0] a_out, b_out;
  logic [1:0]  a_oe, b_oe;

  int checks = 0, fails = 0, contention = 0;
  bit done = 0;
  int ref_ab[2], ref_ba[2];

  always #4 clk = ~clk;

  dual_latch_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_drv_n(ab_drv_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_drv_n(ba_drv_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
  );

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare all outputs against the behavioural model for this cycle
  task automatic check_all(string tag);
    int exp_b, exp_a, exp_boe, exp_aoe;
    exp_b = 0; exp_a = 0; exp_boe = 0; exp_aoe = 0;
    for (int s = 0; s < 2; s++) begin
      int ain, bin, v;
      bit open, drv;
      ain = (a_in >> (8*s)) & 8'hff;
      bin = (b_in >> (8*s)) & 8'hff;
      open = rst_n && !ab_en_n[s] && !ab_le_n[s];
      drv  = rst_n && !ab_en_n[s] && !ab_drv_n[s];
      v = open ? ain : ref_ab[s];
      if (drv) begin exp_b |= v << (8*s); exp_boe |= 1 << s; end
      open = rst_n && !ba_en_n[s] && !ba_le_n[s];
      drv  = rst_n && !ba_en_n[s] && !ba_drv_n[s];
      v = open ? bin : ref_ba[s];
      if (drv) begin exp_a |= v << (8*s); exp_aoe |= 1 << s; end
    end
    if ((exp_aoe & exp_boe) != 0) contention++;
    cmp(tag, "b_out", int'(b_out), exp_b);
    cmp(tag, "b_oe",  int'(b_oe),  exp_boe);
    cmp(tag, "a_out", int'(a_out), exp_a);
    cmp(tag, "a_oe",  int'(a_oe),  exp_aoe);
  endtask

  // One cycle: inputs already set at negedge; check, then advance model
  task automatic step(string tag);
    #1 check_all(tag);
    @(posedge clk);
    for (int s = 0; s < 2; s++) begin
      if (!rst_n) begin ref_ab[s] = 0; ref_ba[s] = 0; end
      else begin
        if (!ab_en_n[s] && !ab_le_n[s]) ref_ab[s] = (a_in >> (8*s)) & 8'hff;
        if (!ba_en_n[s] && !ba_le_n[s]) ref_ba[s] = (b_in >> (8*s)) & 8'hff;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    ref_ab = '{0, 0}; ref_ba = '{0, 0};
    @(negedge clk);
    // R1: reset holds drives off even with enables low
    ab_en_n = 0; ab_drv_n = 0; ab_le_n = 0; a_in = 16'h5aa5;
    step("R1"); step("R1");
    ab_le_n = 2'b11; ab_en_n = 2'b11; ab_drv_n = 2'b11;
    rst_n = 1;
    step("R1");
    // R1: closed latch drives zero after reset
    ab_en_n = 0; ab_drv_n = 0; ba_en_n = 0; ba_drv_n = 0;
    a_in = 16'h1234; b_in = 16'h4321;
    step("R1");
    // R3: transparent A to B
    ab_le_n = 0;
    for (int i = 0; i < 4; i++) begin a_in = 16'h1111 * (i + 3); step("R3"); end
    // R4: close and change inputs
    ab_le_n = 2'b11;
    for (int i = 0; i < 4; i++) begin a_in = 16'h0f0f ^ (16'h0101 * i); step("R4"); end
    // R6: B-to-A transparent then stored
    ba_le_n = 0;
    for (int i = 0; i < 3; i++) begin b_in = 16'h2468 + 16'h0303 * i; step("R6"); end
    ba_le_n = 2'b11;
    for (int i = 0; i < 3; i++) begin b_in = ~b_in; step("R6"); end
    // R2: chip enable high, latch enable low: no capture, no drive
    ab_en_n = 2'b11; ab_le_n = 0; ba_en_n = 2'b11; ba_le_n = 0;
    for (int i = 0; i < 3; i++) begin a_in = 16'hdead + i; b_in = 16'hbeef - i; step("R2"); end
    ab_le_n = 2'b11; ba_le_n = 2'b11; ab_en_n = 0; ba_en_n = 0;
    step("R2");
    // R5: drive enable toggling gates outputs
    ab_drv_n = 2'b01; ba_drv_n = 2'b10; step("R5");
    ab_drv_n = 2'b11; ba_drv_n = 2'b11; step("R5");
    ab_drv_n = 0; ba_drv_n = 0;
    // R7: section 0 open, section 1 closed
    ab_le_n = 2'b10; ba_le_n = 2'b01;
    for (int i = 0; i < 3; i++) begin a_in = 16'h7700 + i * 16'h0111; b_in = 16'h00aa + i * 16'h1010; step("R7"); end
    ab_le_n = 2'b11; ba_le_n = 2'b11;
    // R8: both directions open and driving
    ab_le_n = 0; ba_le_n = 0;
    for (int i = 0; i < 3; i++) begin a_in = 16'hc3c3 + i; b_in = 16'h3c3c - i; step("R8"); end
    // R5: random control and data patterns
    for (int i = 0; i < 1500; i++) begin
      {ab_en_n, ab_le_n, ab_drv_n} = 6'($urandom);
      {ba_en_n, ba_le_n, ba_drv_n} = 6'($urandom);
      a_in = 16'($urandom); b_in = 16'($urandom);
      if (i == 700) rst_n = 0;
      if (i == 703) rst_n = 1;
      step("R5");
    end
    done = 1;
    $display("contention events: %0d", contention);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule